// File: doc/BRIEF.md
# Staggered 4x4 SAD Search Group

This block runs a full block-matching search for one 4x4 current partition over a square window of candidate positions, spanning -RANGE to +RANGE in both directions. Nine processing elements (with the default RANGE of 4) each own one horizontal offset. Each element adds one absolute pixel difference per cycle and so finishes a 4x4 sum in sixteen cycles. It then moves at once to the same horizontal offset one window row further down.

Element k starts one cycle after element k-1. Because of this stagger, a single current-block pixel is fetched per cycle and passed along a delay chain that feeds every element. A selector and a comparator follow the element outputs. They keep the smallest sum seen so far and the displacement where it occurred.

Before each run, the current partition and the search window are written in as pixel streams while the block is idle. A start pulse then launches the scan. With the default parameters, the last candidate is produced 152 cycles into the scan.

Top module: `sad_row_scan_group`

## Requirements
- R1: While idle, each `cur_we` cycle stores `cur_pix` at the next current-block slot. Slots are filled row-major, slot = row*4+col. Each `win_we` cycle stores `win_pix` at the next window slot. The window is 12x12 and is filled row-major, slot = row*12+col. Window row 0 is vertical offset -4 and window column 0 is horizontal offset -4. An accepted start sends both write positions back to slot 0.
- R2: The result for candidate (dy,dx) equals the sum over i,j in 0..3 of |cur[i][j] - win[i+dy+4][j+dx+4]|. It is 12 bits wide, and the largest possible value is 4080.
- R3: Count m from 0 at the cycle right after the clock edge that accepts start. The result for horizontal offset index k (dx = k-4) and window row r is shown on lane k of `sad_bus` (bits k*12 +: 12). At the same time `sad_vld[k]` is high for exactly one cycle, at m = 16 + k + 16*r.
- R4: A start pulse that arrives while a scan is in progress, up to and including the cycle in which `best_vld` is high, is ignored. The running scan keeps its timing and its results.
- R5: At most one bit of `sad_vld` is high in any cycle. Results come out in raster order: rows first, then columns.
- R6: The reported best value is the minimum over all 81 candidates. When two candidates have equal sums, the one earlier in raster order is kept.
- R7: `best_dx` = k-4 and `best_dy` = r-4 for the winning candidate. Both are 4-bit two's complement.
- R8: `best_vld` is high for exactly one cycle, at m = 153. The best outputs then hold their values until the first result of the next scan.
- R9: Writes on `cur_we` or `win_we` during a scan are ignored, and the stored pixels stay unchanged for later scans.
- R10: After reset, `sad_vld` and `best_vld` are low and the best value and vector are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_we | input | 1 | Current-block pixel write strobe |
| cur_pix | input | 8 | Current-block pixel |
| win_we | input | 1 | Window pixel write strobe |
| win_pix | input | 8 | Window pixel |
| start | input | 1 | Launch a scan (ignored while busy) |
| sad_vld | output | 9 | Per-element result strobe |
| sad_bus | output | 108 | Per-element 12-bit sums, lane k at k*12 |
| best_sad | output | 12 | Smallest sum found |
| best_dx | output | 4 | Signed horizontal offset of the best candidate |
| best_dy | output | 4 | Signed vertical offset of the best candidate |
| best_vld | output | 1 | Final best result strobe |

## Verification
The bench builds the block with its defaults: 8-bit pixels, 4x4 partition and range 4. That configuration is small enough to check every one of the 81 candidate sums against an arithmetic reference, in every cycle of every scan, together with the exact cycle and lane of each strobe. Window contents are chosen to reach the extremes: all-equal data, where every sum is zero and the tie rule decides; full-scale differences giving 4080; and two exact copies planted at different offsets, including a negative one. Stray writes and a second start during a scan, followed by a rescan of the unchanged data, show that the stores and the schedule cannot be disturbed.

// File: rtl/sadg_pkg.sv
package sadg_pkg;

  function automatic int unsigned pix_absdiff(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // window slot read by element pe at its local step
  function automatic int win_addr(int step, int pe, int blk, int win_w);
    int blk_pix;
    int pix;
    int row;
    blk_pix = blk * blk;
    pix     = step % blk_pix;
    row     = step / blk_pix;
    return (row + pix / blk) * win_w + pe + pix % blk;
  endfunction

  function automatic int sad_ceiling(int pix_w, int blk);
    return blk * blk * ((1 << pix_w) - 1);
  endfunction

endpackage

// File: rtl/pix_store.sv
module pix_store #(
  parameter int DEPTH = 16,
  parameter int PIX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   we,
  input  logic [PIX_W-1:0]       wdata,
  output logic [DEPTH*PIX_W-1:0] mem_flat
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] wptr;
  logic             wrap;

  assign wrap = (int'(wptr) == DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wptr <= '0;
    else if (clr) wptr <= '0;
    else if (we)  wptr <= wrap ? '0 : wptr + 1'b1;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mem_flat[e*PIX_W +: PIX_W] <= '0;
      else if (we && int'(wptr) == e)     mem_flat[e*PIX_W +: PIX_W] <= wdata;
    end
  end

  // R9
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem_flat));

endmodule

// File: rtl/sad_pe.sv
module sad_pe
  import sadg_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int PIX_W   = 8,
  parameter int BLK     = 4,
  parameter int NUM_ROW = 9,
  parameter int WIN_W   = 12,
  parameter int CNT_W   = 8,
  parameter int SAD_W   = 12,
  parameter int ROW_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scan_on,
  input  logic [CNT_W-1:0]             tick,
  input  logic [PIX_W-1:0]             cur_px,
  input  logic [WIN_W*WIN_W*PIX_W-1:0] win_flat,
  output logic                         done,
  output logic [SAD_W-1:0]             sad,
  output logic [ROW_W-1:0]             row
);
  localparam int BLK_PIX = BLK * BLK;
  localparam int SPAN    = NUM_ROW * BLK_PIX;

  int               step;
  int               waddr;
  logic             pe_busy;
  logic             first_pix;
  logic             last_pix;
  logic [PIX_W-1:0] win_px;
  logic [PIX_W-1:0] diff;
  logic [SAD_W-1:0] acc;
  logic [SAD_W-1:0] acc_next;

  always_comb begin
    step      = int'(tick) - IDX;
    pe_busy   = scan_on && (step >= 0) && (step < SPAN);
    first_pix = pe_busy && ((step % BLK_PIX) == 0);
    last_pix  = pe_busy && ((step % BLK_PIX) == BLK_PIX - 1);
    waddr     = pe_busy ? win_addr(step, IDX, BLK, WIN_W) : 0;
    win_px    = win_flat[waddr*PIX_W +: PIX_W];
    diff      = PIX_W'(pix_absdiff(int'(cur_px), int'(win_px)));
    acc_next  = (first_pix ? '0 : acc) + SAD_W'(diff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      done <= 1'b0;
      sad  <= '0;
      row  <= '0;
    end else begin
      done <= last_pix;
      if (pe_busy) acc <= acc_next;
      if (last_pix) begin
        sad <= acc_next;
        row <= ROW_W'(step / BLK_PIX);
      end
    end
  end

  // R2
  sad_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(sad) <= sad_ceiling(PIX_W, BLK)));

  // R3
  pe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/min_tracker.sv
module min_tracker #(
  parameter int NUM_PE = 9,
  parameter int SAD_W  = 12,
  parameter int ROW_W  = 4,
  parameter int MV_W   = 4,
  parameter int RANGE  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [NUM_PE-1:0]       done_vec,
  input  logic [NUM_PE*SAD_W-1:0] sad_bus,
  input  logic [NUM_PE*ROW_W-1:0] row_bus,
  output logic [SAD_W-1:0]        best_sad,
  output logic signed [MV_W-1:0]  best_dx,
  output logic signed [MV_W-1:0]  best_dy,
  output logic                    best_vld
);
  logic             cand_vld;
  logic             cand_better;
  logic             last_cand;
  logic             seen;
  logic [SAD_W-1:0] cand_sad;
  logic [ROW_W-1:0] cand_row;
  logic [MV_W-1:0]  cand_col;

  always_comb begin
    cand_sad = '0;
    cand_row = '0;
    cand_col = '0;
    for (int k = 0; k < NUM_PE; k++) begin
      if (done_vec[k]) begin
        cand_sad = sad_bus[k*SAD_W +: SAD_W];
        cand_row = row_bus[k*ROW_W +: ROW_W];
        cand_col = MV_W'(k);
      end
    end
    cand_vld    = |done_vec;
    cand_better = cand_vld && (!seen || (cand_sad < best_sad));
    last_cand   = done_vec[NUM_PE-1] && (int'(cand_row) == NUM_PE - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      best_vld <= 1'b0;
      best_sad <= '0;
      best_dx  <= '0;
      best_dy  <= '0;
    end else if (clr) begin
      seen     <= 1'b0;
      best_vld <= 1'b0;
    end else begin
      best_vld <= last_cand;
      if (cand_vld) seen <= 1'b1;
      if (cand_better) begin
        best_sad <= cand_sad;
        best_dx  <= cand_col - MV_W'(RANGE);
        best_dy  <= MV_W'(cand_row) - MV_W'(RANGE);
      end
    end
  end

  // R6
  min_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vld && !clr) |=> (best_sad <= $past(cand_sad)));

  // R6
  tie_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vld && seen && !clr && cand_sad == best_sad) |=>
      ($stable(best_dx) && $stable(best_dy)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    best_vld |=> !best_vld);

endmodule

// File: rtl/sad_row_scan_group.sv
module sad_row_scan_group #(
  parameter int PIX_W = 8,
  parameter int BLK   = 4,
  parameter int RANGE = 4,
  localparam int NUM_PE  = 2 * RANGE + 1,
  localparam int BLK_PIX = BLK * BLK,
  localparam int WIN_W   = BLK + 2 * RANGE,
  localparam int SAD_W   = PIX_W + $clog2(BLK_PIX),
  localparam int MV_W    = $clog2(RANGE + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cur_we,
  input  logic [PIX_W-1:0]        cur_pix,
  input  logic                    win_we,
  input  logic [PIX_W-1:0]        win_pix,
  input  logic                    start,
  output logic [NUM_PE-1:0]       sad_vld,
  output logic [NUM_PE*SAD_W-1:0] sad_bus,
  output logic [SAD_W-1:0]        best_sad,
  output logic signed [MV_W-1:0]  best_dx,
  output logic signed [MV_W-1:0]  best_dy,
  output logic                    best_vld
);
  localparam int NUM_ROW  = NUM_PE;
  localparam int WIN_PIX  = WIN_W * WIN_W;
  localparam int SCAN_LEN = (NUM_PE - 1) + NUM_ROW * BLK_PIX;
  localparam int CNT_W    = $clog2(SCAN_LEN + 1);
  localparam int ROW_W    = $clog2(NUM_ROW);

  logic                      busy_q;
  logic                      scan_on;
  logic [CNT_W-1:0]          tick;
  logic                      go;
  logic                      scan_last;
  logic [BLK_PIX*PIX_W-1:0]  cur_flat;
  logic [WIN_PIX*PIX_W-1:0]  win_flat;
  logic [PIX_W-1:0]          cur_tap [NUM_PE];
  logic [NUM_PE*ROW_W-1:0]   row_bus;

  assign go        = start && !busy_q;
  assign scan_last = (int'(tick) == SCAN_LEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      scan_on <= 1'b0;
      tick    <= '0;
    end else begin
      if (go)            busy_q <= 1'b1;
      else if (best_vld) busy_q <= 1'b0;
      if (go) begin
        scan_on <= 1'b1;
        tick    <= '0;
      end else if (scan_on) begin
        if (scan_last) scan_on <= 1'b0;
        else           tick    <= tick + 1'b1;
      end
    end
  end

  pix_store #(.DEPTH(BLK_PIX), .PIX_W(PIX_W)) u_cur_store (
    .clk(clk), .rst_n(rst_n), .clr(go), .we(cur_we && !busy_q),
    .wdata(cur_pix), .mem_flat(cur_flat)
  );

  pix_store #(.DEPTH(WIN_PIX), .PIX_W(PIX_W)) u_win_store (
    .clk(clk), .rst_n(rst_n), .clr(go), .we(win_we && !busy_q),
    .wdata(win_pix), .mem_flat(win_flat)
  );

  // one current pixel per cycle, handed down the element chain
  always_comb begin
    cur_tap[0] = cur_flat[(int'(tick) % BLK_PIX)*PIX_W +: PIX_W];
  end

  for (genvar k = 1; k < NUM_PE; k++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_tap[k] <= '0;
      else        cur_tap[k] <= cur_tap[k-1];
    end
  end

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    sad_pe #(
      .IDX(k), .PIX_W(PIX_W), .BLK(BLK), .NUM_ROW(NUM_ROW), .WIN_W(WIN_W),
      .CNT_W(CNT_W), .SAD_W(SAD_W), .ROW_W(ROW_W)
    ) u_pe (
      .clk(clk), .rst_n(rst_n), .scan_on(scan_on), .tick(tick),
      .cur_px(cur_tap[k]), .win_flat(win_flat),
      .done(sad_vld[k]), .sad(sad_bus[k*SAD_W +: SAD_W]),
      .row(row_bus[k*ROW_W +: ROW_W])
    );
  end

  min_tracker #(
    .NUM_PE(NUM_PE), .SAD_W(SAD_W), .ROW_W(ROW_W), .MV_W(MV_W), .RANGE(RANGE)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .clr(go), .done_vec(sad_vld),
    .sad_bus(sad_bus), .row_bus(row_bus),
    .best_sad(best_sad), .best_dx(best_dx), .best_dy(best_dy),
    .best_vld(best_vld)
  );

  // R5
  one_finisher_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sad_vld));

  // R4
  scan_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_on && !scan_last) |=> (tick == $past(tick) + 1'b1));

  // R8
  done_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(best_vld) |-> (!scan_on && busy_q));

endmodule

// File: tb/test_sad_row_scan_group.sv
`timescale 1ns/1ps
module test_sad_row_scan_group;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cur_we = 1'b0, win_we = 1'b0, start = 1'b0;
  logic [7:0]   cur_pix = '0, win_pix = '0;
  logic [8:0]   sad_vld;
  logic [107:0] sad_bus;
  logic [11:0]  best_sad;
  logic signed [3:0] best_dx, best_dy;
  logic         best_vld;

  int cur_ref [16];
  int win_ref [144];
  int tests = 0, fails = 0;
  int unsigned seed = 32'h1234_5678;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sad_row_scan_group i_sad_row_scan_group (
    .clk(clk), .rst_n(rst_n), .cur_we(cur_we), .cur_pix(cur_pix),
    .win_we(win_we), .win_pix(win_pix), .start(start),
    .sad_vld(sad_vld), .sad_bus(sad_bus), .best_sad(best_sad),
    .best_dx(best_dx), .best_dy(best_dy), .best_vld(best_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 16) & 32'hff);
  endfunction

  // R2 reference: r,k are window row / column indices 0..8
  function automatic int ref_sad(int r, int k);
    int s = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        int d = cur_ref[i*4+j] - win_ref[(r+i)*12 + k + j];
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  // R1: raster load order for both stores
  task automatic load_all();
    for (int p = 0; p < 16; p++) begin
      cur_we = 1'b1; cur_pix = 8'(cur_ref[p]);
      @(negedge clk);
    end
    cur_we = 1'b0;
    for (int p = 0; p < 144; p++) begin
      win_we = 1'b1; win_pix = 8'(win_ref[p]);
      @(negedge clk);
    end
    win_we = 1'b0;
  endtask

  task automatic run_job(input bit noisy, input int want_dx, input int want_dy);
    int best_v = 0, bk = 0, br = 0;
    for (int r = 0; r < 9; r++)
      for (int k = 0; k < 9; k++) begin
        int v = ref_sad(r, k);
        if ((r == 0 && k == 0) || v < best_v) begin best_v = v; bk = k; br = r; end
      end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int m = 0; m < 160; m++) begin
      logic [8:0] exp_vld = '0;
      for (int k = 0; k < 9; k++) begin
        int q = m - 16 - k;
        if (q >= 0 && q % 16 == 0 && q / 16 < 9) exp_vld[k] = 1'b1;
      end
      chk(sad_vld == exp_vld, "R3/R5 strobe", int'(sad_vld), int'(exp_vld));
      for (int k = 0; k < 9; k++)
        if (exp_vld[k] && sad_vld[k]) begin
          int e = ref_sad((m - 16 - k) / 16, k);
          chk(int'(sad_bus[k*12 +: 12]) == e, "R2 lane sum", int'(sad_bus[k*12 +: 12]), e);
        end
      chk(best_vld == (m == 153), "R8 best strobe", int'(best_vld), int'(m == 153));
      if (m == 153 || m == 158) begin
        chk(int'(best_sad) == best_v, "R6 best sum", int'(best_sad), best_v);
        chk(int'(best_dx) == bk - 4, "R7 dx", int'(best_dx), bk - 4);
        chk(int'(best_dy) == br - 4, "R7 dy", int'(best_dy), br - 4);
        if (want_dx != 99) begin
          chk(int'(best_dx) == want_dx, "R6 tie/plant dx", int'(best_dx), want_dx);
          chk(int'(best_dy) == want_dy, "R6 tie/plant dy", int'(best_dy), want_dy);
        end
      end
      // R4 and R9 disturbance while running
      start   = noisy && (m == 60 || m == 153);
      win_we  = noisy && m >= 20 && m < 40;
      cur_we  = noisy && m >= 20 && m < 40;
      win_pix = 8'(m * 7);
      cur_pix = 8'(m * 3);
      @(negedge clk);
    end
    start = 1'b0; win_we = 1'b0; cur_we = 1'b0;
  endtask

  task automatic plant(input int dy, input int dx);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        win_ref[(dy+4+i)*12 + dx+4+j] = cur_ref[i*4+j];
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(sad_vld == '0, "R10 sad_vld", int'(sad_vld), 0);
    chk(best_vld == 1'b0, "R10 best_vld", int'(best_vld), 0);
    chk(best_sad == '0 && best_dx == '0 && best_dy == '0, "R10 best", int'(best_sad), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // random data
    for (int p = 0; p < 16; p++)  cur_ref[p] = rnd8();
    for (int p = 0; p < 144; p++) win_ref[p] = rnd8();
    load_all();
    run_job(1'b0, 99, 99);

    // all equal: every sum zero, first candidate kept (R6)
    for (int p = 0; p < 16; p++)  cur_ref[p] = 7;
    for (int p = 0; p < 144; p++) win_ref[p] = 7;
    load_all();
    run_job(1'b0, -4, -4);

    // full-scale difference: 4080 everywhere (R2)
    for (int p = 0; p < 16; p++)  cur_ref[p] = 255;
    for (int p = 0; p < 144; p++) win_ref[p] = 0;
    load_all();
    run_job(1'b0, -4, -4);

    // two exact copies: earlier raster position wins (R6, R7)
    for (int p = 0; p < 16; p++)  cur_ref[p] = 100 + 9 * p;
    for (int p = 0; p < 144; p++) win_ref[p] = 0;
    plant(1, 2);
    plant(3, -4);
    load_all();
    run_job(1'b0, 2, 1);

    // stray writes and starts during the scan (R4, R9), then rescan unchanged data
    run_job(1'b1, 2, 1);
    run_job(1'b0, 2, 1);

    // single copy at a negative vertical offset (R7)
    for (int p = 0; p < 144; p++) win_ref[p] = rnd8() / 4;
    plant(-3, 3);
    load_all();
    run_job(1'b0, 3, -3);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule